// File: doc/BRIEF.md
# Priority Virtual-Lane Coherence Message Arbiter

This block merges coherence traffic from three virtual lanes onto one inter-node output link. The lanes are: an I/O lane, a low-priority lane that carries requests headed to a line's home node, and a high-priority lane that carries forwarded requests and every reply. Each lane has its own small FIFO and its own downstream credit counter. A message that is stuck for lack of credit on one lane therefore never holds back another lane. The arbiter picks strictly by priority among the lanes that have both a queued message and a credit. As a result, replies and forwards always drain, and the protocol needs neither negative acknowledgements nor retries.

The block also holds the owner side of a writeback. When a line is written back to its home, its address and data are captured in a hold register. The register keeps them until an acknowledgement naming the same address arrives. While the line is held, a forwarded request that hits its address is answered directly from the held data.

Top module: `vc_lane_arbiter`

## Requirements
- R1: While reset is asserted, `out_valid` is 0, `wb_busy` is 0, `wb_ready` is 1 and all three `in_ready` bits are 1.
- R2: Lane encoding is 0 = I/O, 1 = low (home requests), 2 = high (forwards and replies), so lane L uses `in_valid[L]`, `in_msg[L*MSG_W +: MSG_W]`, `credit_ret[L]` and `out_lane` = L. A lane is eligible when its FIFO is non-empty and its credit count is nonzero. At most one lane is granted per cycle, with high above low and low above I/O. A message granted in one cycle appears on `out_valid`/`out_lane`/`out_msg` for exactly one cycle after the next clock edge.
- R3: Each lane's credit count starts at CREDIT_INIT (default 2). A grant decrements it, a pulse on `credit_ret[L]` increments it, and it never exceeds CREDIT_MAX. A lane with zero credit is never granted.
- R4: A lane with no credit or no message does not block a lower-priority lane that is eligible.
- R5: Each lane FIFO holds DEPTH (default 4) messages and keeps their order. `in_ready[L]` is 0 while that lane's FIFO is full, and a message offered then is dropped without affecting the lane's contents.
- R6: `wb_load` while `wb_ready` is 1 captures `wb_addr`/`wb_data` and sets `wb_busy`. The hold is released only by `ack_valid` with `ack_addr` equal to the held address. An acknowledgement with any other address leaves the hold unchanged.
- R7: `fwd_hit` is 1 exactly when `fwd_valid` is 1, a line is held and `fwd_addr` equals its address. While `fwd_hit` is 1, `fwd_data` equals the held data.
- R8: `wb_load` while a line is held is ignored (`wb_ready` = 0). The held address and data are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Per-lane message offer |
| in_msg | input | 3*MSG_W | Per-lane message payloads, lane L at bits L*MSG_W |
| in_ready | output | 3 | Per-lane FIFO not full |
| credit_ret | input | 3 | Per-lane credit return pulse from downstream |
| out_valid | output | 1 | Message present on the output link |
| out_lane | output | 2 | Lane of the output message |
| out_msg | output | MSG_W | Output message payload |
| wb_load | input | 1 | Capture a writeback into the hold register |
| wb_addr | input | AW | Writeback line address |
| wb_data | input | DW | Writeback line data |
| wb_ready | output | 1 | Hold register free |
| wb_busy | output | 1 | A writeback is held awaiting acknowledgement |
| ack_valid | input | 1 | Home acknowledgement strobe |
| ack_addr | input | AW | Address named by the acknowledgement |
| fwd_valid | input | 1 | Forwarded request lookup strobe |
| fwd_addr | input | AW | Forwarded request line address |
| fwd_hit | output | 1 | Forward hits the held line |
| fwd_data | output | DW | Held data returned for a hit |

## Verification
A wrong credit count shows up at the ports within a few cycles. With too few credits, a lane stops emitting before it has sent CREDIT_INIT messages. With too many, a lane emits past its allowance while the link should be silent. A wrong priority decision or a corrupted FIFO pointer appears on the very next output beat, as an unexpected `out_lane` or an out-of-order payload against the per-lane scoreboard. A hold register that releases on the wrong acknowledgement drops `wb_busy` and `fwd_hit` in the cycle after that acknowledgement.

// File: rtl/vl_pkg.sv
package vl_pkg;
  localparam int NUM_LANES = 3;

  typedef enum logic [1:0] {
    LANE_IO = 2'd0,
    LANE_LO = 2'd1,
    LANE_HI = 2'd2
  } lane_e;

  // strict priority: high lane, then low lane, then I/O lane
  function automatic logic [NUM_LANES-1:0] pick_grant(input logic [NUM_LANES-1:0] elig);
    logic [NUM_LANES-1:0] g;
    g = '0;
    if (elig[LANE_HI])      g[LANE_HI] = 1'b1;
    else if (elig[LANE_LO]) g[LANE_LO] = 1'b1;
    else if (elig[LANE_IO]) g[LANE_IO] = 1'b1;
    return g;
  endfunction

  function automatic logic [1:0] lane_of(input logic [NUM_LANES-1:0] g);
    logic [1:0] l;
    if (g[LANE_HI])      l = LANE_HI;
    else if (g[LANE_LO]) l = LANE_LO;
    else                 l = LANE_IO;
    return l;
  endfunction
endpackage

// File: rtl/vl_fifo.sv
module vl_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= wrap_inc(wr_ptr);
      end
      if (pop && !empty) rd_ptr <= wrap_inc(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/vl_credit.sv
module vl_credit #(
  parameter int MAX  = 4,
  parameter int INIT = 2,
  parameter int CW   = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ret,
  input  logic          take,
  output logic [CW-1:0] count,
  output logic          zero
);
  function automatic logic [CW-1:0] credit_step(input logic [CW-1:0] c,
                                                input logic r, input logic t);
    int v;
    v = int'(c) + (r ? 1 : 0) - (t ? 1 : 0);
    if (v > MAX) v = MAX;
    if (v < 0)   v = 0;
    return CW'(v);
  endfunction

  assign zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= CW'(INIT);
    else        count <= credit_step(count, ret, take);
  end
endmodule

// File: rtl/vl_wb_hold.sv
module vl_wb_hold #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic          ack_valid,
  input  logic [AW-1:0] ack_addr,
  input  logic          fwd_valid,
  input  logic [AW-1:0] fwd_addr,
  output logic          busy,
  output logic [AW-1:0] held_addr,
  output logic [DW-1:0] held_data,
  output logic          hit
);
  logic take_in, release_hold;

  assign take_in      = load && !busy;
  assign release_hold = busy && ack_valid && (ack_addr == held_addr);
  assign hit          = busy && fwd_valid && (fwd_addr == held_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      held_addr <= '0;
      held_data <= '0;
    end else begin
      if (take_in) begin
        busy      <= 1'b1;
        held_addr <= load_addr;
        held_data <= load_data;
      end else if (release_hold) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vc_lane_arbiter.sv
module vc_lane_arbiter
  import vl_pkg::*;
#(
  parameter int MSG_W       = 16,
  parameter int DEPTH       = 4,
  parameter int CREDIT_MAX  = 4,
  parameter int CREDIT_INIT = 2,
  parameter int AW          = 8,
  parameter int DW          = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             in_valid,
  input  logic [3*MSG_W-1:0]     in_msg,
  output logic [2:0]             in_ready,
  input  logic [2:0]             credit_ret,
  output logic                   out_valid,
  output logic [1:0]             out_lane,
  output logic [MSG_W-1:0]       out_msg,
  input  logic                   wb_load,
  input  logic [AW-1:0]          wb_addr,
  input  logic [DW-1:0]          wb_data,
  output logic                   wb_ready,
  output logic                   wb_busy,
  input  logic                   ack_valid,
  input  logic [AW-1:0]          ack_addr,
  input  logic                   fwd_valid,
  input  logic [AW-1:0]          fwd_addr,
  output logic                   fwd_hit,
  output logic [DW-1:0]          fwd_data
);
  localparam int CW = $clog2(CREDIT_MAX + 1);

  // named internal events for the checker
  logic [NUM_LANES-1:0]    fifo_empty, fifo_full;
  logic [NUM_LANES-1:0]    credit_zero;
  logic [NUM_LANES-1:0]    eligible;
  logic [NUM_LANES-1:0]    grant;
  logic [NUM_LANES*CW-1:0] credit_flat;
  logic [MSG_W-1:0]        head [NUM_LANES];
  logic [1:0]              sel_lane;
  logic [AW-1:0]           hold_addr;
  logic [DW-1:0]           hold_data;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    vl_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[l]),
      .wdata (in_msg[l*MSG_W +: MSG_W]),
      .pop   (grant[l]),
      .head  (head[l]),
      .empty (fifo_empty[l]),
      .full  (fifo_full[l])
    );

    vl_credit #(.MAX(CREDIT_MAX), .INIT(CREDIT_INIT), .CW(CW)) u_credit (
      .clk   (clk),
      .rst_n (rst_n),
      .ret   (credit_ret[l]),
      .take  (grant[l]),
      .count (credit_flat[l*CW +: CW]),
      .zero  (credit_zero[l])
    );

    assign in_ready[l] = !fifo_full[l];
    assign eligible[l] = !fifo_empty[l] && !credit_zero[l];
  end

  assign grant    = pick_grant(eligible);
  assign sel_lane = lane_of(grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lane  <= LANE_IO;
      out_msg   <= '0;
    end else begin
      out_valid <= |grant;
      if (|grant) begin
        out_lane <= sel_lane;
        out_msg  <= head[sel_lane];
      end
    end
  end

  vl_wb_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wb_load),
    .load_addr (wb_addr),
    .load_data (wb_data),
    .ack_valid (ack_valid),
    .ack_addr  (ack_addr),
    .fwd_valid (fwd_valid),
    .fwd_addr  (fwd_addr),
    .busy      (wb_busy),
    .held_addr (hold_addr),
    .held_data (hold_data),
    .hit       (fwd_hit)
  );

  assign wb_ready = !wb_busy;
  assign fwd_data = hold_data;
endmodule

// File: rtl/vc_lane_arbiter_chk.sv
module vc_lane_arbiter_chk #(
  parameter int CW = 3,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    eligible,
  input logic [2:0]    grant,
  input logic [2:0]    credit_zero,
  input logic [3*CW-1:0] credit_flat,
  input logic [2:0]    credit_ret,
  input logic          out_valid,
  input logic          wb_busy,
  input logic          ack_valid,
  input logic [AW-1:0] ack_addr,
  input logic [AW-1:0] hold_addr,
  input logic [DW-1:0] hold_data
);
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_high_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eligible[2] |-> grant[2]);

  a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != 3'b000) |=> out_valid);

  a_r3_no_zero_credit_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & credit_zero) == 3'b000);

  a_r4_low_lane_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible == 3'b001) |-> grant[0]);

  for (genvar l = 0; l < 3; l++) begin : g_cr
    a_r3_credit_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[l] && !credit_ret[l]) |=>
        credit_flat[l*CW +: CW] == $past(credit_flat[l*CW +: CW]) - 1'b1);
  end

  a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_busy && !(ack_valid && ack_addr == hold_addr)) |=>
      (wb_busy && $stable(hold_addr) && $stable(hold_data)));
endmodule

bind vc_lane_arbiter vc_lane_arbiter_chk #(.CW(CW), .AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eligible    (eligible),
  .grant       (grant),
  .credit_zero (credit_zero),
  .credit_flat (credit_flat),
  .credit_ret  (credit_ret),
  .out_valid   (out_valid),
  .wb_busy     (wb_busy),
  .ack_valid   (ack_valid),
  .ack_addr    (ack_addr),
  .hold_addr   (hold_addr),
  .hold_data   (hold_data)
);

// File: tb/vc_lane_arbiter_bench.sv
`timescale 1ns/1ps
module vc_lane_arbiter_bench;
  localparam int MW = 16;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [2:0]      in_valid;
  logic [3*MW-1:0] in_msg;
  logic [2:0]      in_ready;
  logic [2:0]      credit_ret;
  logic            out_valid;
  logic [1:0]      out_lane;
  logic [MW-1:0]   out_msg;
  logic            wb_load, wb_ready, wb_busy;
  logic [AW-1:0]   wb_addr, ack_addr, fwd_addr;
  logic [DW-1:0]   wb_data, fwd_data;
  logic            ack_valid, fwd_valid, fwd_hit;

  vc_lane_arbiter u_vc_lane_arbiter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .in_ready(in_ready), .credit_ret(credit_ret), .out_valid(out_valid),
    .out_lane(out_lane), .out_msg(out_msg), .wb_load(wb_load),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(wb_ready),
    .wb_busy(wb_busy), .ack_valid(ack_valid), .ack_addr(ack_addr),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_hit(fwd_hit),
    .fwd_data(fwd_data)
  );

  int vecs = 0;
  int fails = 0;
  int out_cnt = 0;
  bit done = 0;
  logic [MW-1:0] q_io[$], q_lo[$], q_hi[$];
  int seen[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int qsize(input int l);
    case (l)
      0: return q_io.size();
      1: return q_lo.size();
      default: return q_hi.size();
    endcase
  endfunction

  // monitor: per-lane scoreboard, R2 / R5 ordering
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [MW-1:0] e;
      out_cnt++;
      seen.push_back(int'(out_lane));
      if (qsize(int'(out_lane)) == 0) begin
        chk(1'b0, "R2 unexpected output", {14'd0, out_lane, out_msg}, 32'd0);
      end else begin
        case (out_lane)
          2'd0: e = q_io.pop_front();
          2'd1: e = q_lo.pop_front();
          default: e = q_hi.pop_front();
        endcase
        chk(out_msg == e, "R5 lane order/payload", out_msg, e);
      end
    end
  end

  // driver: offer on lanes in mask; expect only accepted ones
  task automatic push(input logic [2:0] mask, input logic [MW-1:0] m);
    @(negedge clk);
    in_valid = mask;
    for (int l = 0; l < 3; l++) begin
      in_msg[l*MW +: MW] = m + MW'(l);
      if (mask[l] && in_ready[l]) begin
        case (l)
          0: q_io.push_back(m + MW'(l));
          1: q_lo.push_back(m + MW'(l));
          default: q_hi.push_back(m + MW'(l));
        endcase
      end
    end
    @(posedge clk); #1;
    in_valid = 3'b000;
  endtask

  task automatic ret(input logic [2:0] mask);
    @(negedge clk);
    credit_ret = mask;
    @(posedge clk); #1;
    credit_ret = 3'b000;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; in_valid = 0; in_msg = '0; credit_ret = 0;
    wb_load = 0; wb_addr = 0; wb_data = 0; ack_valid = 0; ack_addr = 0;
    fwd_valid = 0; fwd_addr = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 3'b111, "R1 in_ready", in_ready, 3'b111);
    chk(wb_busy == 0 && wb_ready == 1, "R1 hold idle", {wb_busy, wb_ready}, 2'b01);
    rst_n = 1;

    // basic traffic on each lane
    push(3'b001, 16'h1000); push(3'b010, 16'h2000); push(3'b100, 16'h3000);
    idle(6);
    ret(3'b111);

    // R2 priority: all three offered together
    base = seen.size();
    push(3'b111, 16'h4000);
    idle(6);
    chk(seen.size() == base + 3, "R2 count", seen.size() - base, 3);
    if (seen.size() == base + 3) begin
      chk(seen[base] == 2, "R2 first high", seen[base], 2);
      chk(seen[base+1] == 1, "R2 second low", seen[base+1], 1);
      chk(seen[base+2] == 0, "R2 third io", seen[base+2], 0);
    end
    ret(3'b111);

    // R3 credit limit on low lane
    base = out_cnt;
    push(3'b010, 16'h5000); push(3'b010, 16'h5100);
    push(3'b010, 16'h5200); push(3'b010, 16'h5300);
    idle(10);
    chk(out_cnt - base == 2, "R3 stops at credit", out_cnt - base, 2);
    ret(3'b010); ret(3'b010);
    idle(6);
    chk(out_cnt - base == 4, "R3 resumes on return", out_cnt - base, 4);
    ret(3'b010); ret(3'b010);

    // R4 high lane out of credit must not block I/O lane
    push(3'b100, 16'h6000); push(3'b100, 16'h6100);
    idle(6);
    base = out_cnt;
    push(3'b101, 16'h6200);
    idle(6);
    chk(out_cnt - base == 1, "R4 one output", out_cnt - base, 1);
    chk(seen[seen.size()-1] == 0, "R4 io proceeds", seen[seen.size()-1], 0);
    chk(q_hi.size() == 1, "R4 high still held", q_hi.size(), 1);
    ret(3'b100);
    idle(6);
    chk(q_hi.size() == 0, "R3 high drains after return", q_hi.size(), 0);
    ret(3'b100); ret(3'b001);

    // R5 FIFO full on I/O lane
    push(3'b001, 16'h7000); push(3'b001, 16'h7100);
    idle(6);
    push(3'b001, 16'h7200); push(3'b001, 16'h7300);
    push(3'b001, 16'h7400); push(3'b001, 16'h7500);
    idle(2);
    chk(in_ready == 3'b110, "R5 full blocks", in_ready, 3'b110);
    push(3'b001, 16'h7F00); // dropped
    repeat (4) ret(3'b001);
    idle(8);
    chk(q_io.size() == 0 && q_lo.size() == 0 && q_hi.size() == 0,
        "R5 all drained", q_io.size(), 0);
    chk(in_ready == 3'b111, "R5 ready again", in_ready, 3'b111);

    // R6..R8 writeback hold
    @(negedge clk); wb_load = 1; wb_addr = 8'h3C; wb_data = 16'hBEEF;
    @(posedge clk); #1; wb_load = 0;
    @(negedge clk);
    chk(wb_busy == 1 && wb_ready == 0, "R6 captured", {wb_busy, wb_ready}, 2'b10);
    fwd_valid = 1; fwd_addr = 8'h3C;
    #1;
    chk(fwd_hit == 1, "R7 hit", fwd_hit, 1);
    chk(fwd_data == 16'hBEEF, "R7 data", fwd_data, 16'hBEEF);
    fwd_addr = 8'h3D;
    #1;
    chk(fwd_hit == 0, "R7 miss other addr", fwd_hit, 0);
    fwd_valid = 0;
    @(negedge clk); wb_load = 1; wb_addr = 8'h11; wb_data = 16'h1234;
    @(posedge clk); #1; wb_load = 0;
    @(negedge clk); fwd_valid = 1; fwd_addr = 8'h3C; #1;
    chk(fwd_hit == 1 && fwd_data == 16'hBEEF, "R8 load ignored", fwd_data, 16'hBEEF);
    fwd_valid = 0;
    @(negedge clk); ack_valid = 1; ack_addr = 8'h3D;
    @(posedge clk); #1; ack_valid = 0;
    @(negedge clk);
    chk(wb_busy == 1, "R6 wrong ack ignored", wb_busy, 1);
    ack_valid = 1; ack_addr = 8'h3C;
    @(posedge clk); #1; ack_valid = 0;
    @(negedge clk);
    chk(wb_busy == 0 && wb_ready == 1, "R6 released", wb_busy, 0);
    fwd_valid = 1; fwd_addr = 8'h3C; #1;
    chk(fwd_hit == 0, "R7 no hit after release", fwd_hit, 1'b0);
    fwd_valid = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule